// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block holds a small, parameterised set of outbound translation regions. Each region is set up through a 32-bit register port and describes one window of the CPU-side address space: a 64-bit base, a 32-bit inclusive upper bound that shares the base's upper 32 bits, a 64-bit target address on the bus side, a transaction-type code and an enable bit.

Every request address is compared against all enabled windows in parallel. When one or more windows contain the address, the lowest-numbered one is chosen. Its target plus the offset of the address into the window is put on the output, along with the region's type code, its index and a hit flag. When no window contains the address, the address passes through unchanged and the hit flag stays low. The lookup is purely combinational. A register write changes the translation from the next clock edge.

Top module: `obx_translate`

## Requirements
- R1: After a synchronous active-low reset, every register of every region reads zero and no request address hits.
- R2: Region n decodes at byte address n*512 plus a word offset: 0x00 type (bits 4:0 stored), 0x04 control (bit 31 enable, bit 30 a stored-only mode flag, all other bits read zero), 0x08 base low, 0x0C base high, 0x10 bound, 0x14 target low, 0x18 target high. Each of these reads back the value last written, under that mask.
- R3: A register write is sampled on the rising clock edge. Readback and translation show the old value before that edge and the new value after it.
- R4: Any other offset inside a region, any address that is not word aligned, and any region index at or above the region count reads as zero. A write there changes no register and no translation.
- R5: An enabled region matches a request when base <= address <= {base high, bound}, with both ends included.
- R6: On a hit, the translated address is target + (address - base), taken modulo 2^64.
- R7: On a hit, the type output carries the matching region's stored type field: memory 0, I/O 2, config type 0 = 4, config type 1 = 5. The region output carries its index.
- R8: When several regions match, the lowest-numbered region wins.
- R9: On a miss, hit is low, the translated address equals the request address, and the type and region outputs are zero.
- R10: A disabled region never matches. The stored mode flag has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the register at cfg_addr |
| req_addr | input | 64 | CPU-side request address |
| xl_hit | output | 1 | A region matched the request |
| xl_addr | output | 64 | Translated (or passed-through) address |
| xl_type | output | 5 | Transaction type of the matching region |
| xl_region | output | CFG_AW-9 | Index of the matching region |

## Verification
The bench builds the block with three regions and a two-bit region index. This leaves index 3 decodable but unbacked, so the rule that unimplemented regions read zero and ignore writes can be checked, while overlapping windows still exercise the priority order. Windows with random bases, sizes, types and enables are probed at and around their ends. Some bases lie near the top of a 32-bit half, where the bound wraps and the window becomes empty.

// File: rtl/obx_pkg.sv
// Shared constants and the region record for the outbound translation unit.
// Assumes 32-bit register words and a 512-byte stride between regions.
package obx_pkg;

    localparam int REGION_SHIFT = 9;
    localparam int TYPE_W       = 5;

    localparam logic [8:0] OFF_TYPE  = 9'h000;
    localparam logic [8:0] OFF_CTRL  = 9'h004;
    localparam logic [8:0] OFF_BASEL = 9'h008;
    localparam logic [8:0] OFF_BASEH = 9'h00C;
    localparam logic [8:0] OFF_BOUND = 9'h010;
    localparam logic [8:0] OFF_TGTL  = 9'h014;
    localparam logic [8:0] OFF_TGTH  = 9'h018;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_MODE_BIT = 30;

    typedef enum logic [TYPE_W-1:0] {
        XT_MEM  = 5'd0,
        XT_IO   = 5'd2,
        XT_CFG0 = 5'd4,
        XT_CFG1 = 5'd5
    } xl_type_e;

    typedef struct packed {
        logic [TYPE_W-1:0] typ;
        logic              en;
        logic              mode;
        logic [31:0]       base_lo;
        logic [31:0]       base_hi;
        logic [31:0]       bound;
        logic [31:0]       tgt_lo;
        logic [31:0]       tgt_hi;
    } region_t;

endpackage

// File: rtl/obx_region_regs.sv
// Register storage for one translation region.
// Assumes the caller has already decoded the region index; only the offset
// within the region arrives here. Unknown offsets read zero, writes are dropped.
module obx_region_regs
    import obx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [8:0]  off,
    input  logic [31:0] wdata,
    output region_t     cfg,
    output logic [31:0] rdata
);

    // Capture a write into the addressed field; reset clears the region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_TYPE:  cfg.typ     <= wdata[TYPE_W-1:0];
                OFF_CTRL: begin
                    cfg.en   <= wdata[CTRL_EN_BIT];
                    cfg.mode <= wdata[CTRL_MODE_BIT];
                end
                OFF_BASEL: cfg.base_lo <= wdata;
                OFF_BASEH: cfg.base_hi <= wdata;
                OFF_BOUND: cfg.bound   <= wdata;
                OFF_TGTL:  cfg.tgt_lo  <= wdata;
                OFF_TGTH:  cfg.tgt_hi  <= wdata;
                default: ;
            endcase
        end
    end

    // Present the addressed field, zero for unused offsets.
    always_comb begin
        rdata = '0;
        case (off)
            OFF_TYPE:  rdata[TYPE_W-1:0] = cfg.typ;
            OFF_CTRL: begin
                rdata[CTRL_EN_BIT]   = cfg.en;
                rdata[CTRL_MODE_BIT] = cfg.mode;
            end
            OFF_BASEL: rdata = cfg.base_lo;
            OFF_BASEH: rdata = cfg.base_hi;
            OFF_BOUND: rdata = cfg.bound;
            OFF_TGTL:  rdata = cfg.tgt_lo;
            OFF_TGTH:  rdata = cfg.tgt_hi;
            default: ;
        endcase
    end

endmodule

// File: rtl/obx_window.sv
// Window test and address arithmetic for one region.
// Assumes the upper end of the window shares the base's upper 32 bits.
module obx_window
    import obx_pkg::*;
(
    input  region_t     cfg,
    input  logic [63:0] req_addr,
    output logic        match,
    output logic [63:0] xl_addr
);

    logic [63:0] base;
    logic [63:0] top;
    logic [63:0] tgt;

    // Assemble the window ends and the target.
    always_comb begin
        base = {cfg.base_hi, cfg.base_lo};
        top  = {cfg.base_hi, cfg.bound};
        tgt  = {cfg.tgt_hi, cfg.tgt_lo};
    end

    // Inclusive range test, gated by the enable bit only.
    always_comb match = cfg.en && (req_addr >= base) && (req_addr <= top);

    // Offset into the window, re-based onto the target.
    always_comb xl_addr = tgt + (req_addr - base);

endmodule

// File: rtl/obx_select.sv
// Fixed-priority choice among matching regions; the lowest index wins.
// Assumes per-region translations are precomputed and valid where matched.
module obx_select
    import obx_pkg::*;
#(
    parameter int NUM = 4,
    parameter int IW  = 2
) (
    input  logic [NUM-1:0]             match,
    input  logic [NUM-1:0][63:0]       addr_arr,
    input  logic [NUM-1:0][TYPE_W-1:0] type_arr,
    input  logic [63:0]                req_addr,
    output logic                       hit,
    output logic [IW-1:0]              idx,
    output logic [63:0]                addr,
    output logic [TYPE_W-1:0]          typ
);

    // Scan from the top down so the lowest matching index is the last assignment.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        addr = req_addr;
        typ  = '0;
        for (int r = NUM - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit  = 1'b1;
                idx  = IW'(r);
                addr = addr_arr[r];
                typ  = type_arr[r];
            end
        end
    end

endmodule

// File: rtl/obx_translate.sv
// Outbound address translation unit: region registers, parallel window
// matching and priority selection. Assumes CFG_AW-9 bits can index every region.
module obx_translate
    import obx_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = REGION_SHIFT + ((NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [63:0]              req_addr,
    output logic                     xl_hit,
    output logic [63:0]              xl_addr,
    output logic [TYPE_W-1:0]        xl_type,
    output logic [CFG_AW-REGION_SHIFT-1:0] xl_region
);

    localparam int IW = CFG_AW - REGION_SHIFT;

    logic [IW-1:0]                      sel_idx;
    logic [8:0]                         sel_off;
    logic [NUM_REGIONS-1:0]             en_vec;
    logic [NUM_REGIONS-1:0]             match_vec;
    logic [NUM_REGIONS-1:0][31:0]       rd_arr;
    logic [NUM_REGIONS-1:0][63:0]       addr_arr;
    logic [NUM_REGIONS-1:0][TYPE_W-1:0] type_arr;

    // Split the register address into region index and offset.
    always_comb begin
        sel_idx = cfg_addr[CFG_AW-1:REGION_SHIFT];
        sel_off = cfg_addr[REGION_SHIFT-1:0];
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        region_t cfg;

        obx_region_regs u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_we && (sel_idx == IW'(r))),
            .off   (sel_off),
            .wdata (cfg_wdata),
            .cfg   (cfg),
            .rdata (rd_arr[r])
        );

        obx_window u_win (
            .cfg      (cfg),
            .req_addr (req_addr),
            .match    (match_vec[r]),
            .xl_addr  (addr_arr[r])
        );

        // Expose per-region enable and type to the selector and checker.
        always_comb begin
            en_vec[r]   = cfg.en;
            type_arr[r] = cfg.typ;
        end
    end

    // Readback mux; indices without a region return zero.
    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (sel_idx == IW'(r)) cfg_rdata = rd_arr[r];
        end
    end

    obx_select #(.NUM(NUM_REGIONS), .IW(IW)) u_sel (
        .match    (match_vec),
        .addr_arr (addr_arr),
        .type_arr (type_arr),
        .req_addr (req_addr),
        .hit      (xl_hit),
        .idx      (xl_region),
        .addr     (xl_addr),
        .typ      (xl_type)
    );

endmodule

// File: rtl/obx_checker.sv
// Temporal checks for the outbound translation unit, bound into the top.
// Assumes en_vec and match_vec come from the region registers and windows.
module obx_checker #(
    parameter int NUM = 4,
    parameter int RW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [63:0]     req_addr,
    input logic            xl_hit,
    input logic [63:0]     xl_addr,
    input logic [4:0]      xl_type,
    input logic [RW-1:0]   xl_region,
    input logic [NUM-1:0]  en_vec,
    input logic [NUM-1:0]  match_vec
);

    AST_RESET_CLEARS_EN: assert property (@(posedge clk) !rst_n |=> (en_vec == '0)); // R1

    AST_EN_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en_vec)); // R3

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_addr == req_addr && xl_type == 5'd0 && xl_region == '0)); // R9

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> ((en_vec >> xl_region) & NUM'(1)) != '0); // R10

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> ((match_vec & ((NUM'(1) << xl_region) - NUM'(1))) == '0)); // R8

endmodule

bind obx_translate obx_checker #(
    .NUM (NUM_REGIONS),
    .RW  (CFG_AW - 9)
) u_obx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .req_addr  (req_addr),
    .xl_hit    (xl_hit),
    .xl_addr   (xl_addr),
    .xl_type   (xl_type),
    .xl_region (xl_region),
    .en_vec    (en_vec),
    .match_vec (match_vec)
);

// File: tb/tb_obx_translate.sv
module tb_obx_translate;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 3;
    localparam int AW         = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] req_addr = '0;
    logic        xl_hit;
    logic [63:0] xl_addr;
    logic [4:0]  xl_type;
    logic [1:0]  xl_region;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model storage.
    logic [4:0]  m_typ [4];
    logic        m_en  [4];
    logic        m_mode[4];
    logic [31:0] m_bl  [4];
    logic [31:0] m_bh  [4];
    logic [31:0] m_bd  [4];
    logic [31:0] m_tl  [4];
    logic [31:0] m_th  [4];

    obx_translate #(.NUM_REGIONS(NREG), .CFG_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .xl_hit(xl_hit), .xl_addr(xl_addr), .xl_type(xl_type), .xl_region(xl_region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        int i = int'(a[10:9]);
        if (i >= NREG) return '0;
        case (a[8:0])
            9'h000: return {27'd0, m_typ[i]};
            9'h004: return {m_en[i], m_mode[i], 30'd0};
            9'h008: return m_bl[i];
            9'h00C: return m_bh[i];
            9'h010: return m_bd[i];
            9'h014: return m_tl[i];
            9'h018: return m_th[i];
            default: return '0;
        endcase
    endfunction

    function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
        int i = int'(a[10:9]);
        if (i >= NREG) return;
        case (a[8:0])
            9'h000: m_typ[i] = d[4:0];
            9'h004: begin m_en[i] = d[31]; m_mode[i] = d[30]; end
            9'h008: m_bl[i] = d;
            9'h00C: m_bh[i] = d;
            9'h010: m_bd[i] = d;
            9'h014: m_tl[i] = d;
            9'h018: m_th[i] = d;
            default: ;
        endcase
    endfunction

    // Expected {hit, region, type, address} for a request.
    function automatic logic [71:0] exp_xl(logic [63:0] a);
        for (int i = 0; i < NREG; i++) begin
            if (m_en[i] && a >= {m_bh[i], m_bl[i]} && a <= {m_bh[i], m_bd[i]})
                return {1'b1, 2'(i), m_typ[i], ({m_th[i], m_tl[i]} + (a - {m_bh[i], m_bl[i]}))};
        end
        return {1'b0, 2'd0, 5'd0, a};
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a);
        cfg_addr = a;
        #1;
        chk(req, {32'd0, cfg_rdata}, {32'd0, exp_read(a)});
    endtask

    task automatic look(string req, logic [63:0] a);
        logic [71:0] e;
        req_addr = a;
        #1;
        e = exp_xl(a);
        chk({req, " hit"},    {63'd0, xl_hit},    {63'd0, e[71]});
        chk({req, " region"}, {62'd0, xl_region}, {62'd0, e[70:69]});
        chk({req, " type"},   {59'd0, xl_type},   {59'd0, e[68:64]});
        chk({req, " addr"},   xl_addr,            e[63:0]);
    endtask

    task automatic prog(int i, logic [63:0] base, logic [31:0] bound,
                        logic [63:0] tgt, logic [4:0] t, bit en, bit mode);
        logic [AW-1:0] b = AW'(i) << 9;
        wr(b | 11'h008, base[31:0]);
        wr(b | 11'h00C, base[63:32]);
        wr(b | 11'h010, bound);
        wr(b | 11'h014, tgt[31:0]);
        wr(b | 11'h018, tgt[63:32]);
        wr(b | 11'h000, {27'd0, t});
        wr(b | 11'h004, {en, mode, 30'h2AAAAAAA});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] tcodes [4] = '{5'd0, 5'd2, 5'd4, 5'd5};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            m_typ[i] = 0; m_en[i] = 0; m_mode[i] = 0; m_bl[i] = 0;
            m_bh[i] = 0; m_bd[i] = 0; m_tl[i] = 0; m_th[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++)
            for (int o = 0; o < 7; o++) rd_chk("R1 reset readback", AW'((i << 9) | (o * 4)));
        look("R1 reset lookup", 64'h0);

        // R2: readback of every field, masks applied
        prog(0, 64'h0000_0001_1000_0000, 32'h1000_FFFF, 64'hAB00_0000_0000_0000, 5'd4, 1, 1);
        for (int o = 0; o < 7; o++) rd_chk("R2 readback", AW'(o * 4));
        wr(11'h000, 32'hFFFF_FFE5);
        rd_chk("R2 type mask", 11'h000);

        // R3: write visible only after the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 11'h010; cfg_wdata = 32'h1000_00FF;
        req_addr = 64'h0000_0001_1000_0800;
        #1;
        chk("R3 old readback before edge", {32'd0, cfg_rdata}, 64'h1000_FFFF);
        chk("R3 old lookup before edge", {63'd0, xl_hit}, 64'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(11'h010, 32'h1000_00FF);
        rd_chk("R3 new readback after edge", 11'h010);
        look("R3 new lookup after edge", 64'h0000_0001_1000_0800);

        // R5/R6/R7: inclusive ends and arithmetic
        look("R5 at base", 64'h0000_0001_1000_0000);
        look("R5 at bound", 64'h0000_0001_1000_00FF);
        look("R5 below base", 64'h0000_0001_0FFF_FFFF);
        look("R5 past bound", 64'h0000_0001_1000_0100);
        look("R6 inside", 64'h0000_0001_1000_0042);

        // R8: overlap, lowest wins; then R10: disable region 0
        prog(1, 64'h0000_0001_1000_0080, 32'h1000_0FFF, 64'h0000_0000_2000_0000, 5'd2, 1, 0);
        look("R8 overlap lowest", 64'h0000_0001_1000_0090);
        look("R7 region1 only", 64'h0000_0001_1000_0200);
        wr(11'h004, 32'h4000_0000);
        rd_chk("R10 mode kept, enable off", 11'h004);
        look("R10 disabled skipped", 64'h0000_0001_1000_0090);

        // R4: unused offsets, misaligned, unbacked region
        wr(11'h01C, 32'hFFFF_FFFF); rd_chk("R4 unused offset", 11'h01C);
        wr(11'h1FC, 32'hFFFF_FFFF); rd_chk("R4 last offset", 11'h1FC);
        wr(11'h20A, 32'hFFFF_FFFF); rd_chk("R4 misaligned", 11'h20A);
        rd_chk("R4 bound intact", 11'h210);
        wr(11'h604, 32'h8000_0000); rd_chk("R4 unbacked region", 11'h604);
        wr(11'h608, 32'h0000_0000); rd_chk("R4 unbacked base", 11'h608);
        look("R4 no effect on lookup", 64'h0000_0001_1000_0200);

        // R9: miss
        look("R9 miss passthrough", 64'hDEAD_BEEF_0000_1234);

        // Random windows and probes (R5 R6 R7 R8 R10)
        for (int round = 0; round < 40; round++) begin
            for (int i = 0; i < NREG; i++) begin
                logic [63:0] b;
                logic [31:0] sz;
                b = {32'($urandom_range(1, 0)), $urandom()};
                if ($urandom_range(3, 0) == 0) b[31:0] = 32'hFFFF_0000 | 32'($urandom_range(65535, 0));
                sz = 32'($urandom_range(65536, 1));
                prog(i, b, b[31:0] + sz - 32'd1, {$urandom(), $urandom()},
                     tcodes[$urandom_range(3, 0)], ($urandom_range(3, 0) != 0), $urandom_range(1, 0) == 1);
            end
            for (int k = 0; k < 30; k++) begin
                int i = int'($urandom_range(NREG - 1, 0));
                logic [63:0] b = {m_bh[i], m_bl[i]};
                logic [63:0] a;
                case ($urandom_range(4, 0))
                    0: a = b;
                    1: a = {m_bh[i], m_bd[i]};
                    2: a = b - 64'd1;
                    3: a = {m_bh[i], m_bd[i]} + 64'd1;
                    default: a = b + 64'($urandom_range(70000, 0));
                endcase
                look("R6 random", a);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule